// File: doc/BRIEF.md
# Register Tag Rename Table

This block is the register file of a small out-of-order core in which every architectural register carries, next to its data, the tag of the reservation station that will produce its next value. Instructions come through an issue port strictly in program order. Each issue names two source registers and one destination register. For each source, the table returns either a usable value or the tag of the station the consumer must wait on. Within the same cycle it records the issuing station's tag in the destination entry, so only the most recent writer of each register is remembered.

A result bus port carries a (tag, value) pair. Every entry still waiting on that tag takes the value and becomes ready. An entry that has since been renamed to a newer tag ignores the older broadcast. This is how write-after-read and write-after-write conflicts disappear while read-after-write order is still honoured. Tag code 0 is reserved as "no producer".

Each entry is a two-state machine. The states are `ENT_READY`, where the value is usable and the tag is null, and `ENT_WAIT`, where the value is not usable and the tag is nonzero. There are four transitions. *rename* goes from `ENT_READY` to `ENT_WAIT` when an issue targets the entry. *re-rename* goes from `ENT_WAIT` to `ENT_WAIT` when a newer tag replaces the old one. *capture* goes from `ENT_WAIT` to `ENT_READY` when the bus tag matches. *hold* keeps the state when nothing applies.

Top module: `rtt_rename_table`

## Requirements
- R1: After reset every register reads as ready, with value 0 and tag 0.
- R2: An issue with a nonzero tag puts its destination register in the waiting state with that tag, visible on the source outputs from the next cycle.
- R3: Each source output is either ready=1 with the value and tag=0, or ready=0 with a nonzero tag and value=0. It is never anything else.
- R4: A bus broadcast with a nonzero tag makes every waiting register whose tag matches ready in the next cycle, holding the broadcast value.
- R5: A broadcast of an older tag, for a register that has since been renamed to a newer tag, leaves that register waiting on the newer tag.
- R6: When an issue renames a register in the same cycle as a broadcast that matches that register's current tag, the issue's new tag wins.
- R7: A source read of a waiting register whose tag equals the tag on the bus in that same cycle returns ready with the bus value (bypass).
- R8: Source reads made in the cycle of an issue see the table as it was before that issue's rename, including when a source is also the destination.
- R9: An issue with tag 0 changes nothing, and a broadcast with tag 0 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request this cycle |
| iss_dst | input | 3 | Destination register index |
| iss_tag | input | 3 | Tag of the station that will produce the destination (0 = none) |
| src_a_sel | input | 3 | First source register index (read every cycle) |
| src_b_sel | input | 3 | Second source register index (read every cycle) |
| bus_valid | input | 1 | Result broadcast present |
| bus_tag | input | 3 | Tag of the finishing station |
| bus_value | input | 16 | Result value |
| src_a_ready | output | 1 | First source value is usable |
| src_a_value | output | 16 | First source value (0 when not ready) |
| src_a_tag | output | 3 | First source producer tag (0 when ready) |
| src_b_ready | output | 1 | Second source value is usable |
| src_b_value | output | 16 | Second source value (0 when not ready) |
| src_b_tag | output | 3 | Second source producer tag (0 when ready) |

## Verification
Renaming by issue and capture from the result bus can land on the same register in the same cycle. So can a source read and a matching broadcast. The bench provokes the first case by renaming a waiting register while the bus carries that register's current tag, then checks one cycle later that the register waits on the new tag. It provokes the second case by holding a waiting register on a source port while the bus carries its tag, and checks in that same cycle that the port shows the bus value as ready before the registered capture becomes visible.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

    parameter int RTT_REGS   = 8;
    parameter int RTT_DATA_W = 16;
    parameter int RTT_TAG_W  = 3;

    // Per-entry state: value usable, or waiting on a producer tag
    typedef enum logic {
        ENT_READY = 1'b0,
        ENT_WAIT  = 1'b1
    } ent_state_e;

endpackage

// File: rtl/rtt_entry.sv
module rtt_entry
    import rtt_pkg::*;
#(
    parameter int DATA_W = RTT_DATA_W,
    parameter int TAG_W  = RTT_TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              bus_hit_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_value,
    output logic              ent_ready,
    output logic [TAG_W-1:0]  ent_tag,
    output logic [DATA_W-1:0] ent_value
);

    ent_state_e        st_q, st_d;
    logic [TAG_W-1:0]  tag_q, tag_d;
    logic [DATA_W-1:0] val_q, val_d;

    // Next-state: rename, re-rename, capture, hold
    always_comb begin
        st_d  = st_q;
        tag_d = tag_q;
        val_d = val_q;
        unique case (st_q)
            ENT_READY: begin
                if (wr_en) begin
                    st_d  = ENT_WAIT;
                    tag_d = wr_tag;
                end
            end
            ENT_WAIT: begin
                if (wr_en) begin
                    tag_d = wr_tag;
                end else if (bus_hit_valid && (bus_tag == tag_q)) begin
                    st_d  = ENT_READY;
                    tag_d = '0;
                    val_d = bus_value;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ENT_READY;
            tag_q <= '0;
            val_q <= '0;
        end else begin
            st_q  <= st_d;
            tag_q <= tag_d;
            val_q <= val_d;
        end
    end

    // Outputs
    always_comb begin
        ent_value = val_q;
        unique case (st_q)
            ENT_READY: begin
                ent_ready = 1'b1;
                ent_tag   = '0;
            end
            ENT_WAIT: begin
                ent_ready = 1'b0;
                ent_tag   = tag_q;
            end
        endcase
    end

endmodule

// File: rtl/rtt_src_port.sv
module rtt_src_port
    import rtt_pkg::*;
#(
    parameter int NUM_REGS = RTT_REGS,
    parameter int DATA_W   = RTT_DATA_W,
    parameter int TAG_W    = RTT_TAG_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [IDX_W-1:0]  sel,
    input  logic              ent_ready [NUM_REGS],
    input  logic [TAG_W-1:0]  ent_tag   [NUM_REGS],
    input  logic [DATA_W-1:0] ent_value [NUM_REGS],
    input  logic              bus_hit_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_value,
    output logic              out_ready,
    output logic [DATA_W-1:0] out_value,
    output logic [TAG_W-1:0]  out_tag
);

    logic              pick_ready;
    logic [TAG_W-1:0]  pick_tag;
    logic [DATA_W-1:0] pick_value;

    always_comb begin
        pick_ready = ent_ready[sel];
        pick_tag   = ent_tag[sel];
        pick_value = ent_value[sel];
    end

    // Value, bypass from bus, or wait tag; never a mix
    always_comb begin
        if (pick_ready) begin
            out_ready = 1'b1;
            out_value = pick_value;
            out_tag   = '0;
        end else if (bus_hit_valid && (bus_tag == pick_tag)) begin
            out_ready = 1'b1;
            out_value = bus_value;
            out_tag   = '0;
        end else begin
            out_ready = 1'b0;
            out_value = '0;
            out_tag   = pick_tag;
        end
    end

endmodule

// File: rtl/rtt_rename_table.sv
module rtt_rename_table
    import rtt_pkg::*;
#(
    parameter int NUM_REGS = RTT_REGS,
    parameter int DATA_W   = RTT_DATA_W,
    parameter int TAG_W    = RTT_TAG_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [IDX_W-1:0]  iss_dst,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic [IDX_W-1:0]  src_a_sel,
    input  logic [IDX_W-1:0]  src_b_sel,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_value,
    output logic              src_a_ready,
    output logic [DATA_W-1:0] src_a_value,
    output logic [TAG_W-1:0]  src_a_tag,
    output logic              src_b_ready,
    output logic [DATA_W-1:0] src_b_value,
    output logic [TAG_W-1:0]  src_b_tag
);

    logic              iss_fire;
    logic              bus_hit_valid;
    logic              ent_ready [NUM_REGS];
    logic [TAG_W-1:0]  ent_tag   [NUM_REGS];
    logic [DATA_W-1:0] ent_value [NUM_REGS];

    // Tag 0 means "no producer" on both ports
    assign iss_fire      = iss_valid && (iss_tag != '0);
    assign bus_hit_valid = bus_valid && (bus_tag != '0);

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_entry
        logic wr_en;
        assign wr_en = iss_fire && (iss_dst == IDX_W'(gi));

        rtt_entry #(
            .DATA_W (DATA_W),
            .TAG_W  (TAG_W)
        ) entry_i (
            .clk           (clk),
            .rst_n         (rst_n),
            .wr_en         (wr_en),
            .wr_tag        (iss_tag),
            .bus_hit_valid (bus_hit_valid),
            .bus_tag       (bus_tag),
            .bus_value     (bus_value),
            .ent_ready     (ent_ready[gi]),
            .ent_tag       (ent_tag[gi]),
            .ent_value     (ent_value[gi])
        );
    end

    rtt_src_port #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .TAG_W    (TAG_W)
    ) port_a_i (
        .sel           (src_a_sel),
        .ent_ready     (ent_ready),
        .ent_tag       (ent_tag),
        .ent_value     (ent_value),
        .bus_hit_valid (bus_hit_valid),
        .bus_tag       (bus_tag),
        .bus_value     (bus_value),
        .out_ready     (src_a_ready),
        .out_value     (src_a_value),
        .out_tag       (src_a_tag)
    );

    rtt_src_port #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .TAG_W    (TAG_W)
    ) port_b_i (
        .sel           (src_b_sel),
        .ent_ready     (ent_ready),
        .ent_tag       (ent_tag),
        .ent_value     (ent_value),
        .bus_hit_valid (bus_hit_valid),
        .bus_tag       (bus_tag),
        .bus_value     (bus_value),
        .out_ready     (src_b_ready),
        .out_value     (src_b_value),
        .out_tag       (src_b_tag)
    );

endmodule

// File: rtl/rtt_table_chk.sv
module rtt_table_chk #(
    parameter int IDX_W  = 3,
    parameter int DATA_W = 16,
    parameter int TAG_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iss_valid,
    input logic [IDX_W-1:0]  iss_dst,
    input logic [TAG_W-1:0]  iss_tag,
    input logic [IDX_W-1:0]  src_a_sel,
    input logic              bus_valid,
    input logic [TAG_W-1:0]  bus_tag,
    input logic              src_a_ready,
    input logic [DATA_W-1:0] src_a_value,
    input logic [TAG_W-1:0]  src_a_tag,
    input logic              src_b_ready,
    input logic [DATA_W-1:0] src_b_value,
    input logic [TAG_W-1:0]  src_b_tag
);

    // R1
    reset_clean_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (src_a_ready && (src_a_value == '0) && (src_a_tag == '0)));

    // R3
    port_a_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_a_ready ? (src_a_tag == '0) : ((src_a_tag != '0) && (src_a_value == '0)));

    // R3
    port_b_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_b_ready ? (src_b_tag == '0) : ((src_b_tag != '0) && (src_b_value == '0)));

    // R2
    rename_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && (iss_tag != '0)) |=>
            ((src_a_sel != $past(iss_dst)) ||
             (bus_valid && (bus_tag == $past(iss_tag))) ||
             (!src_a_ready && (src_a_tag == $past(iss_tag)))));

    // R7
    bypass_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && (bus_tag != '0)) |-> (src_a_ready || (src_a_tag != bus_tag)));

endmodule

bind rtt_rename_table rtt_table_chk #(
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .iss_valid   (iss_valid),
    .iss_dst     (iss_dst),
    .iss_tag     (iss_tag),
    .src_a_sel   (src_a_sel),
    .bus_valid   (bus_valid),
    .bus_tag     (bus_tag),
    .src_a_ready (src_a_ready),
    .src_a_value (src_a_value),
    .src_a_tag   (src_a_tag),
    .src_b_ready (src_b_ready),
    .src_b_value (src_b_value),
    .src_b_tag   (src_b_tag)
);

// File: tb/rtt_rename_table_tb.sv
module rtt_rename_table_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [2:0]  iss_dst = '0;
    logic [2:0]  iss_tag = '0;
    logic [2:0]  src_a_sel = '0;
    logic [2:0]  src_b_sel = '0;
    logic        bus_valid = 1'b0;
    logic [2:0]  bus_tag = '0;
    logic [15:0] bus_value = '0;
    logic        src_a_ready, src_b_ready;
    logic [15:0] src_a_value, src_b_value;
    logic [2:0]  src_a_tag, src_b_tag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rtt_rename_table dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .iss_valid   (iss_valid),
        .iss_dst     (iss_dst),
        .iss_tag     (iss_tag),
        .src_a_sel   (src_a_sel),
        .src_b_sel   (src_b_sel),
        .bus_valid   (bus_valid),
        .bus_tag     (bus_tag),
        .bus_value   (bus_value),
        .src_a_ready (src_a_ready),
        .src_a_value (src_a_value),
        .src_a_tag   (src_a_tag),
        .src_b_ready (src_b_ready),
        .src_b_value (src_b_value),
        .src_b_tag   (src_b_tag)
    );

    // Compare one source port against {ready, value, tag}
    task automatic check_src(input string req, input bit port_b,
                             input logic exp_rdy, input logic [15:0] exp_val,
                             input logic [2:0] exp_tag);
        logic [19:0] act, exp;
        act = port_b ? {src_b_ready, src_b_value, src_b_tag}
                     : {src_a_ready, src_a_value, src_a_tag};
        exp = {exp_rdy, exp_val, exp_tag};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s port %s: actual rdy=%0b val=%h tag=%0d expected rdy=%0b val=%h tag=%0d",
                     req, port_b ? "b" : "a", act[19], act[18:3], act[2:0],
                     exp_rdy, exp_val, exp_tag);
        end
    endtask

    task automatic idle();
        iss_valid = 1'b0;
        bus_valid = 1'b0;
        iss_tag   = '0;
        bus_tag   = '0;
        bus_value = '0;
    endtask

    // Drive an issue for one cycle (called at a negedge)
    task automatic issue(input logic [2:0] dst, input logic [2:0] tag);
        iss_valid = 1'b1;
        iss_dst   = dst;
        iss_tag   = tag;
        @(negedge clk);
        idle();
    endtask

    task automatic broadcast(input logic [2:0] tag, input logic [15:0] val);
        bus_valid = 1'b1;
        bus_tag   = tag;
        bus_value = val;
        @(negedge clk);
        idle();
    endtask

    task automatic read_pair(input string req, input logic [2:0] ra, input logic [2:0] rb,
                             input logic ea_r, input logic [15:0] ea_v, input logic [2:0] ea_t,
                             input logic eb_r, input logic [15:0] eb_v, input logic [2:0] eb_t);
        src_a_sel = ra;
        src_b_sel = rb;
        #1;
        check_src(req, 1'b0, ea_r, ea_v, ea_t);
        check_src(req, 1'b1, eb_r, eb_v, eb_t);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 8; i++) begin
            // R1 R3: every register ready with zero after reset
            read_pair("R1", 3'(i), 3'(7 - i), 1'b1, 16'h0, 3'd0, 1'b1, 16'h0, 3'd0);
        end
        @(negedge clk);
    endtask

    task automatic t_rename();
        issue(3'd3, 3'd5);
        // R2 R3: R3 waits on tag 5, neighbour untouched
        read_pair("R2", 3'd3, 3'd2, 1'b0, 16'h0, 3'd5, 1'b1, 16'h0, 3'd0);
        @(negedge clk);
    endtask

    task automatic t_capture();
        issue(3'd4, 3'd5);
        broadcast(3'd5, 16'h1234);
        // R4: both waiters on tag 5 captured
        read_pair("R4", 3'd3, 3'd4, 1'b1, 16'h1234, 3'd0, 1'b1, 16'h1234, 3'd0);
        @(negedge clk);
    endtask

    task automatic t_waw();
        issue(3'd2, 3'd1);
        issue(3'd2, 3'd2);
        broadcast(3'd1, 16'hAAAA);
        // R5: stale tag 1 ignored, still waiting on tag 2
        read_pair("R5", 3'd2, 3'd1, 1'b0, 16'h0, 3'd2, 1'b1, 16'h0, 3'd0);
        broadcast(3'd2, 16'h0BEE);
        read_pair("R4", 3'd2, 3'd2, 1'b1, 16'h0BEE, 3'd0, 1'b1, 16'h0BEE, 3'd0);
        @(negedge clk);
    endtask

    task automatic t_same_cycle();
        issue(3'd6, 3'd3);
        iss_valid = 1'b1;
        iss_dst   = 3'd6;
        iss_tag   = 3'd4;
        bus_valid = 1'b1;
        bus_tag   = 3'd3;
        bus_value = 16'h3333;
        @(negedge clk);
        idle();
        // R6: issue's new tag wins over same-cycle capture
        read_pair("R6", 3'd6, 3'd6, 1'b0, 16'h0, 3'd4, 1'b0, 16'h0, 3'd4);
        broadcast(3'd4, 16'h4444);
        read_pair("R6", 3'd6, 3'd0, 1'b1, 16'h4444, 3'd0, 1'b1, 16'h0, 3'd0);
        @(negedge clk);
    endtask

    task automatic t_bypass();
        issue(3'd7, 3'd6);
        bus_valid = 1'b1;
        bus_tag   = 3'd6;
        bus_value = 16'h6666;
        // R7: same-cycle bypass of the broadcast value
        read_pair("R7", 3'd7, 3'd1, 1'b1, 16'h6666, 3'd0, 1'b1, 16'h0, 3'd0);
        @(negedge clk);
        idle();
        read_pair("R7", 3'd7, 3'd7, 1'b1, 16'h6666, 3'd0, 1'b1, 16'h6666, 3'd0);
        @(negedge clk);
    endtask

    task automatic t_read_before_write();
        iss_valid = 1'b1;
        iss_dst   = 3'd3;
        iss_tag   = 3'd7;
        // R8: sources read old R3 during its own rename
        read_pair("R8", 3'd3, 3'd3, 1'b1, 16'h1234, 3'd0, 1'b1, 16'h1234, 3'd0);
        @(negedge clk);
        idle();
        read_pair("R8", 3'd3, 3'd4, 1'b0, 16'h0, 3'd7, 1'b1, 16'h1234, 3'd0);
        broadcast(3'd7, 16'h7777);
        read_pair("R4", 3'd3, 3'd3, 1'b1, 16'h7777, 3'd0, 1'b1, 16'h7777, 3'd0);
        @(negedge clk);
    endtask

    task automatic t_null_tag();
        issue(3'd5, 3'd0);
        // R9: tag-0 issue leaves R5 ready
        read_pair("R9", 3'd5, 3'd3, 1'b1, 16'h0, 3'd0, 1'b1, 16'h7777, 3'd0);
        broadcast(3'd0, 16'hFFFF);
        // R9: tag-0 broadcast writes no register
        read_pair("R9", 3'd5, 3'd3, 1'b1, 16'h0, 3'd0, 1'b1, 16'h7777, 3'd0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rename();
        t_capture();
        t_waw();
        t_same_cycle();
        t_bypass();
        t_read_before_write();
        t_null_tag();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=complete");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule